// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

This block is an eight-stage parallel-in, serial-out register. It runs entirely on one fast system clock. It does not use the external shift clock as a clock. Instead it samples three slow control pins: the shift clock, a clock inhibit and an active-low load strobe. From those samples it rebuilds how they act together. The two clocking pins are merged by OR into one effective clock, so a rising edge on either pin can advance the data. Holding the load strobe low copies the parallel word into the stages. This copy wins over every other input.

The last stage drives a true serial output and its inverse. A one-cycle flag warns when the inhibit pin rises while the clock pin is low. That transition causes a shift the user most likely did not intend. The clock and inhibit pins, and the load strobe, each pass through a two-flop synchroniser. The parallel word and the serial input are sampled directly, at the system edge that performs the load or shift.

Top module: `gated_piso`

## Requirements
- R1: While reset is active, all stages are zero, `q_out` is 0, `q_out_n` is 1 and `inh_warn` is 0.
- R2: Once a low on `ld_n_pin` has passed the synchroniser, the stages copy `par_in` on every system cycle. `par_in[7]` goes to the stage next to the output and `par_in[0]` to the stage next to the serial input. The levels of `sclk_pin`, `inh_pin` and `ser_in` have no effect during this time.
- R3: With `ld_n_pin` high and `inh_pin` low, a rising edge on `sclk_pin` shifts once. Every stage moves one place toward the output and `ser_in` enters the first stage. The new bit appears on `q_out` after the third system edge that follows the pin change.
- R4: A rising edge on `sclk_pin` while `inh_pin` is high causes no shift.
- R5: A rising edge on `inh_pin` while `sclk_pin` is low causes exactly one shift, the same as a clock edge.
- R6: `inh_warn` is high for exactly one cycle when `inh_pin` rises while `sclk_pin` is low, in the same cycle that the resulting shift shows on `q_out`. It stays low when `inh_pin` rises while `sclk_pin` is high.
- R7: No shift happens unless the synchronised `ld_n_pin` was already high in the previous sampled cycle. A clock edge that arrives together with the release of the load strobe is therefore ignored.
- R8: When neither a load nor a shift is due, the stages hold their value, whatever `par_in` and `ser_in` do.
- R9: `q_out_n` is always the inverse of `q_out`.
- R10: After a load, eight shifts present `par_in[7]` first and `par_in[0]` last on `q_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| par_in | input | 8 | Parallel data word |
| ser_in | input | 1 | Serial input to the first stage |
| sclk_pin | input | 1 | External shift clock, asynchronous |
| inh_pin | input | 1 | External clock inhibit, asynchronous |
| ld_n_pin | input | 1 | Active-low parallel load strobe, asynchronous |
| q_out | output | 1 | Last stage, true polarity |
| q_out_n | output | 1 | Last stage, inverted |
| inh_warn | output | 1 | One-cycle pulse on an unsafe inhibit rise |

## Verification
The hardest case to reach is a clock edge that arrives together with the release of the load strobe. Only an exact alignment of the two pins makes the one-cycle history of the load strobe decide whether a shift happens. The stimulus changes `ld_n_pin` and `sclk_pin` on the same falling system edge, so both pass through the synchronisers side by side. A stray shift would then flip a known `q_out` bit. The unsafe inhibit rise takes a set-up sequence first: the clock pin is brought high behind a high inhibit and then lowered, so that only the following inhibit rise can produce the edge.

// File: rtl/gpiso_pkg.sv
package gpiso_pkg;
  typedef struct packed {
    logic sclk;
    logic inh;
    logic ld_n;
  } pin_t;

  localparam int PIN_W = $bits(pin_t);
  localparam pin_t PIN_IDLE = '{sclk: 1'b0, inh: 1'b0, ld_n: 1'b1};
endpackage

// File: rtl/gpiso_sync.sv
module gpiso_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb chain_d[s] = din;
      end else begin : g_next
        always_comb chain_d[s] = chain_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= RST_VAL;
        else        chain_q[s] <= chain_d[s];
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gpiso_gate.sv
module gpiso_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic inh_s,
  input  logic ld_n_s,
  output logic shift_en,
  output logic load_en,
  output logic warn
);
  logic eff_q, eff_d;
  logic ld_hi_q, ld_hi_d;
  logic inh_q, inh_d;
  logic warn_q, warn_d;

  // merged clock and its rising edge, plus the unsafe-inhibit detector
  always_comb begin
    eff_d    = sclk_s | inh_s;
    ld_hi_d  = ld_n_s;
    inh_d    = inh_s;
    load_en  = ~ld_n_s;
    shift_en = eff_d & ~eff_q & ld_n_s & ld_hi_q;
    warn_d   = inh_s & ~inh_q & ~sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q   <= 1'b0;
      ld_hi_q <= 1'b1;
      inh_q   <= 1'b0;
      warn_q  <= 1'b0;
    end else begin
      eff_q   <= eff_d;
      ld_hi_q <= ld_hi_d;
      inh_q   <= inh_d;
      warn_q  <= warn_d;
    end
  end

  assign warn = warn_q;
endmodule

// File: rtl/gpiso_shifter.sv
module gpiso_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             shift_en,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  output logic [WIDTH-1:0] stages
);
  logic [WIDTH-1:0] stages_q, stages_d;
  logic             stage_en;

  // load overrides shift; index WIDTH-1 is nearest the output
  always_comb begin
    stage_en = load_en | shift_en;
    if (load_en) stages_d = par_in;
    else         stages_d = {stages_q[WIDTH-2:0], ser_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stages_q <= '0;
    else if (stage_en) stages_q <= stages_d;
  end

  assign stages = stages_q;
endmodule

// File: rtl/gated_piso.sv
module gated_piso #(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  input  logic             sclk_pin,
  input  logic             inh_pin,
  input  logic             ld_n_pin,
  output logic             q_out,
  output logic             q_out_n,
  output logic             inh_warn
);
  import gpiso_pkg::*;

  logic [1:0]       rst_pipe_q;
  logic             rst_i_n;
  pin_t             pins_raw, pins_s;
  logic [PIN_W-1:0] pins_s_vec;
  logic             shift_en, load_en;
  logic [WIDTH-1:0] stages;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_i_n = rst_pipe_q[1];

  assign pins_raw = '{sclk: sclk_pin, inh: inh_pin, ld_n: ld_n_pin};

  gpiso_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_i_n),
    .din  (pins_raw),
    .dout (pins_s_vec)
  );
  assign pins_s = pin_t'(pins_s_vec);

  gpiso_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .sclk_s  (pins_s.sclk),
    .inh_s   (pins_s.inh),
    .ld_n_s  (pins_s.ld_n),
    .shift_en(shift_en),
    .load_en (load_en),
    .warn    (inh_warn)
  );

  gpiso_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .load_en (load_en),
    .shift_en(shift_en),
    .par_in  (par_in),
    .ser_in  (ser_in),
    .stages  (stages)
  );

  assign q_out   = stages[WIDTH-1];
  assign q_out_n = ~stages[WIDTH-1];
endmodule

// File: rtl/gated_piso_chk.sv
module gated_piso_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_i_n,
  input logic         load_en,
  input logic         shift_en,
  input logic         ld_n_s,
  input logic [W-1:0] par_in,
  input logic         ser_in,
  input logic [W-1:0] stages,
  input logic         q_out,
  input logic         inh_warn
);
  always @(posedge clk) begin
    if (!rst_i_n) begin
      a_r1_reset_clear: assert (q_out == 1'b0 && inh_warn == 1'b0)
        else $error("R1 outputs not cleared in reset");
    end
  end

  a_r2_load_copies: assert property (@(posedge clk) disable iff (!rst_i_n)
    load_en |=> stages == $past(par_in));

  a_r3_shift_moves: assert property (@(posedge clk) disable iff (!rst_i_n)
    shift_en |=> stages == {$past(stages[W-2:0]), $past(ser_in)});

  a_r7_no_early_shift: assert property (@(posedge clk) disable iff (!rst_i_n)
    !$past(ld_n_s) |-> !shift_en);

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!load_en && !shift_en) |=> $stable(stages));

  a_r6_warn_single: assert property (@(posedge clk) disable iff (!rst_i_n)
    inh_warn |=> !inh_warn);
endmodule

bind gated_piso gated_piso_chk #(.W(WIDTH)) u_chk (
  .clk     (clk),
  .rst_i_n (rst_i_n),
  .load_en (load_en),
  .shift_en(shift_en),
  .ld_n_s  (pins_s.ld_n),
  .par_in  (par_in),
  .ser_in  (ser_in),
  .stages  (stages),
  .q_out   (q_out),
  .inh_warn(inh_warn)
);

// File: tb/sim_gated_piso.sv
`timescale 1ns/1ps
module sim_gated_piso;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] par_in;
  logic       ser_in, sclk_pin, inh_pin, ld_n_pin;
  logic       q_out, q_out_n, inh_warn;

  int checks = 0;
  int errors = 0;
  int warn_cnt = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gated_piso u0 (
    .clk(clk), .rst_n(rst_n), .par_in(par_in), .ser_in(ser_in),
    .sclk_pin(sclk_pin), .inh_pin(inh_pin), .ld_n_pin(ld_n_pin),
    .q_out(q_out), .q_out_n(q_out_n), .inh_warn(inh_warn)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: pin histories as queues, register as an integer
  bit ch[$], ih[$], lh[$];
  int mreg;
  bit mwarn, eff_last, ld_last, inh_last;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch = '{1'b0, 1'b0}; ih = '{1'b0, 1'b0}; lh = '{1'b1, 1'b1};
      mreg = 0; mwarn = 1'b0; eff_last = 1'b0; ld_last = 1'b1; inh_last = 1'b0;
    end else begin
      bit c, i, l, eff;
      c = ch[0]; i = ih[0]; l = lh[0];
      eff = c | i;
      if (!l) mreg = int'(par_in);
      else if (eff && !eff_last && ld_last) mreg = ((mreg << 1) | int'(ser_in)) & 255;
      mwarn = i && !inh_last && !c;
      eff_last = eff; ld_last = l; inh_last = i;
      void'(ch.pop_front()); ch.push_back(sclk_pin);
      void'(ih.pop_front()); ih.push_back(inh_pin);
      void'(lh.pop_front()); lh.push_back(ld_n_pin);
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk("R8 model q_out", int'(q_out), (mreg >> 7) & 1);
      chk("R9 model q_out_n", int'(q_out_n), ((mreg >> 7) & 1) ^ 1);
      chk("R6 model inh_warn", int'(inh_warn), int'(mwarn));
    end
    if (rst_n && inh_warn) warn_cnt++;
  end

  task automatic wn(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    bit [7:0] pat;
    rst_n = 1'b0; par_in = 8'h00; ser_in = 1'b0;
    sclk_pin = 1'b0; inh_pin = 1'b0; ld_n_pin = 1'b1;
    wn(3);
    chk("R1 q_out in reset", int'(q_out), 0);
    chk("R1 q_out_n in reset", int'(q_out_n), 1);
    chk("R1 inh_warn in reset", int'(inh_warn), 0);
    rst_n = 1'b1;
    wn(1);
    cmp_on = 1'b1;
    wn(4);

    // R2: load follows par_in, ignoring other pins
    par_in = 8'hA5; ld_n_pin = 1'b0; wn(4);
    chk("R2 load A5 msb", int'(q_out), 1);
    chk("R9 inverse after load", int'(q_out_n), 0);
    par_in = 8'h3C; sclk_pin = 1'b1; ser_in = 1'b1; wn(3);
    chk("R2 load tracks 3C despite clock", int'(q_out), 0);
    sclk_pin = 1'b0; wn(3);

    // R10 / R3: serialise 3C msb first, then serial input appears
    ld_n_pin = 1'b1; wn(4);
    pat = 8'h3C;
    for (int k = 0; k < 8; k++) begin
      chk("R10 serial order", int'(q_out), int'(pat[7-k]));
      sclk_pin = 1'b1; wn(3);
      sclk_pin = 1'b0; wn(3);
    end
    chk("R3 serial input reached output", int'(q_out), 1);

    // R4: clock edge blocked by high inhibit
    par_in = 8'h55; ld_n_pin = 1'b0; wn(3);
    ld_n_pin = 1'b1; wn(4);
    chk("R2 load 55 msb", int'(q_out), 0);
    sclk_pin = 1'b1; wn(4);
    chk("R3 clock edge shifts", int'(q_out), 1);
    inh_pin = 1'b1; wn(4);
    sclk_pin = 1'b0; wn(4);
    sclk_pin = 1'b1; wn(4);
    chk("R4 inhibited edge no shift", int'(q_out), 1);
    chk("R6 no warn with clock high", warn_cnt, 0);

    // R5 / R6: inhibit rise with clock low shifts and warns
    inh_pin = 1'b0; wn(4);
    sclk_pin = 1'b0; wn(4);
    inh_pin = 1'b1; wn(3);
    chk("R5 inhibit rise shifts", int'(q_out), 0);
    chk("R6 warn pulse present", int'(inh_warn), 1);
    wn(1);
    chk("R6 warn pulse ends", int'(inh_warn), 0);
    chk("R5 single shift", int'(q_out), 0);
    inh_pin = 1'b0; wn(4);

    // R7: clock edge together with load release is ignored
    ld_n_pin = 1'b0; wn(4);
    chk("R2 reload 55", int'(q_out), 0);
    ld_n_pin = 1'b1; sclk_pin = 1'b1; wn(6);
    chk("R7 edge at release ignored", int'(q_out), 0);
    sclk_pin = 1'b0; wn(4);
    sclk_pin = 1'b1; wn(4);
    chk("R7 later edge shifts", int'(q_out), 1);

    // R8: hold while idle with data inputs moving
    par_in = 8'h00; ser_in = 1'b0; wn(3);
    ser_in = 1'b1; par_in = 8'hFF; wn(3);
    chk("R8 hold while idle", int'(q_out), 1);
    chk("R6 total warn pulses", warn_cnt, 1);

    cmp_on = 1'b0;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule